// File: doc/BRIEF.md
# Mailbox Ring Servicing Engine

This block is the adapter side of a host-memory mailbox ring. Host software sets up a ring of `NMBOX` outgoing mailboxes followed directly by `NMBOX` incoming mailboxes, starting at a base address. The host then signals the engine with a one-cycle start pulse. The engine walks the outgoing mailboxes in order through a byte-wide memory port. It collects each start or abort request, marks the slot free again, and hands the control-block pointer to a command-execution interface. That interface is a simple valid/ready handshake that stands in for the bus execution logic.

When the execution side reports a finished command, the engine posts the pointer, the completion code and, in the wide layout, both status bytes into the next incoming mailbox. It then raises the incoming-mailbox-loaded interrupt. The mailbox layout is chosen when the ring is configured. The narrow layout uses 4-byte slots with a 24-bit pointer, most significant byte first. The wide layout uses 8-byte slots with a 32-bit pointer, least significant byte first. Both layouts use the same slot walker.

The engine keeps a small table of outstanding start requests. An abort request for a pointer that is not in the table is answered at once with a "not found" completion and is never passed on.

Top module: `mbox_ring_engine`

## Requirements
- R1: After reset, `mem_req`, `cmd_valid`, `done_ready` and `irq_mbl` are all low.
- R2: Narrow layout (`cfg_wide`=0): slot s starts at base+4*s. The code is at byte offset 0 and the 24-bit pointer is at offsets 1..3, most significant byte first. `cmd_ptr` carries the pointer with bits 31:24 zero.
- R3: Wide layout (`cfg_wide`=1): slot s starts at base+8*s. The 32-bit pointer is at offsets 0..3, least significant byte first, and the code is at offset 7.
- R4: Outgoing code 0x01 is a start request and code 0x02 is an abort request. After fetching either, the engine writes 0x00 to that slot's code byte. A start request is issued with `cmd_abort`=0, and an abort request for an outstanding pointer is issued with `cmd_abort`=1.
- R5: A start pulse begins a scan at the current outgoing index and visits slots in order. The scan stops at the first slot whose code is 0x00, and that index is not advanced. The outgoing index wraps from NMBOX-1 to 0.
- R6: Narrow completion: the pointer is written to offsets 1..3, most significant byte first, and the completion code is written to offset 0 last.
- R7: Wide completion: the pointer goes to offsets 0..3, least significant byte first, adapter status to offset 4, device status to offset 5, 0x00 to the pad at offset 6, and the completion code to offset 7 last. A selection timeout (adapter status 0x11) is passed through unchanged.
- R8: After configuration the incoming index is NMBOX. It advances after each completion and wraps from 2*NMBOX-1 back to NMBOX.
- R9: Before posting, the engine reads the target incoming slot's code byte. While that byte is non-zero, nothing is written and `done_ready` stays low.
- R10: An abort request whose pointer matches no outstanding start is not issued. Instead it produces a completion with code 0x03 and that pointer.
- R11: `irq_mbl` rises after a completion's code byte is written and stays high until `irq_clr`. A set in the same cycle as `irq_clr` wins.
- R12: `cmd_valid` stays high with a stable `cmd_ptr` and `cmd_abort` until `cmd_ready`. `done_ready` is a one-cycle pulse, given only while `done_valid` is high, in the cycle the completion code byte is written.
- R13: `mem_req` stays high with a stable address, direction and write data until `mem_ack`. Each `mem_ack` ends one byte transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configure ring (taken while idle); resets indices and outstanding table |
| cfg_wide | input | 1 | Layout select: 0 = 4-byte/24-bit, 1 = 8-byte/32-bit |
| cfg_base | input | AW | Ring base address |
| scan_go | input | 1 | Start pulse: scan outgoing mailboxes |
| irq_clr | input | 1 | Clears the loaded interrupt |
| irq_mbl | output | 1 | Incoming mailbox loaded interrupt |
| mem_req | output | 1 | Memory byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 8 | Read data |
| cmd_valid | output | 1 | Command to execution side |
| cmd_abort | output | 1 | 1 = abort request, 0 = start request |
| cmd_ptr | output | 32 | Control-block pointer |
| cmd_ready | input | 1 | Execution side accepts command |
| done_valid | input | 1 | Execution side reports completion |
| done_ptr | input | 32 | Completed control-block pointer |
| done_code | input | 8 | Completion code (0x01 ok, 0x02 aborted, 0x04 error) |
| done_ast | input | 8 | Adapter status |
| done_dst | input | 8 | Device status |
| done_ready | output | 1 | Completion posted |

## Verification
The assertions assume the execution side holds `done_valid` and its fields steady until `done_ready`. They also assume the memory returns `mem_ack` only while a request is pending. The bench models memory with a fixed two-cycle acknowledge that only ever answers a live request. It drives each completion at a falling edge and withdraws it only after the acknowledging edge. Host-side edits to the ring go through the same memory model, one byte per cycle, so host writes never race the engine's accesses.

// File: rtl/mbox_ring_engine.sv
module mbox_ring_engine #(
  parameter int NMBOX = 8,
  parameter int NOUT  = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_wide,
  input  logic [AW-1:0] cfg_base,
  input  logic          scan_go,
  input  logic          irq_clr,
  output logic          irq_mbl,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          cmd_valid,
  output logic          cmd_abort,
  output logic [31:0]   cmd_ptr,
  input  logic          cmd_ready,
  input  logic          done_valid,
  input  logic [31:0]   done_ptr,
  input  logic [7:0]    done_code,
  input  logic [7:0]    done_ast,
  input  logic [7:0]    done_dst,
  output logic          done_ready
);
  localparam int IW = $clog2(2 * NMBOX);
  localparam int TW = (NOUT > 1) ? $clog2(NOUT) : 1;
  localparam logic [IW-1:0] OUT_LAST = IW'(NMBOX - 1);
  localparam logic [IW-1:0] IN_FIRST = IW'(NMBOX);
  localparam logic [IW-1:0] IN_LAST  = IW'(2 * NMBOX - 1);

  typedef enum logic [2:0] {S_IDLE, S_OCODE, S_OPTR, S_OCLR, S_DISP, S_ICHK, S_IWR} st_t;

  st_t            state;
  logic           wide, scan, irq, nf_pend, c_ext;
  logic [AW-1:0]  base;
  logic [IW-1:0]  oidx, iidx, slot;
  logic [2:0]     k, off, klast_rd, klast_wr;
  logic [7:0]     ocode, c_code, c_ast, c_dst, wd;
  logic [31:0]    ptr, nf_ptr, c_ptr;
  logic [NOUT-1:0] tv;
  logic [31:0]    tp [NOUT];
  logic [TW-1:0]  fidx;
  logic           hit;

  assign klast_rd = wide ? 3'd3 : 3'd2;
  assign klast_wr = wide ? 3'd7 : 3'd3;
  assign slot     = (state == S_ICHK || state == S_IWR) ? iidx : oidx;

  always_comb begin
    off = 3'd0;
    case (state)
      S_OCODE, S_OCLR, S_ICHK: off = wide ? 3'd7 : 3'd0;
      S_OPTR:                  off = wide ? k : k + 3'd1;
      S_IWR:                   off = wide ? k : ((k == 3'd3) ? 3'd0 : k + 3'd1);
      default:                 off = 3'd0;
    endcase
  end

  always_comb begin
    wd = 8'h00;
    if (state == S_IWR) begin
      if (wide) begin
        case (k)
          3'd0: wd = c_ptr[7:0];
          3'd1: wd = c_ptr[15:8];
          3'd2: wd = c_ptr[23:16];
          3'd3: wd = c_ptr[31:24];
          3'd4: wd = c_ast;
          3'd5: wd = c_dst;
          3'd6: wd = 8'h00;
          default: wd = c_code;
        endcase
      end else begin
        case (k)
          3'd0: wd = c_ptr[23:16];
          3'd1: wd = c_ptr[15:8];
          3'd2: wd = c_ptr[7:0];
          default: wd = c_code;
        endcase
      end
    end
  end

  always_comb begin
    hit  = 1'b0;
    fidx = '0;
    for (int i = NOUT - 1; i >= 0; i--)
      if (!tv[i]) fidx = TW'(i);
    for (int i = 0; i < NOUT; i++)
      if (tv[i] && tp[i] == ptr) hit = 1'b1;
  end

  assign mem_req    = (state == S_OCODE) || (state == S_OPTR) || (state == S_OCLR) ||
                      (state == S_ICHK) || (state == S_IWR);
  assign mem_we     = (state == S_OCLR) || (state == S_IWR);
  assign mem_addr   = base + (AW'(slot) << (wide ? 3 : 2)) + AW'(off);
  assign mem_wdata  = wd;
  assign cmd_valid  = (state == S_DISP);
  assign cmd_abort  = (ocode == 8'h02);
  assign cmd_ptr    = ptr;
  assign irq_mbl    = irq;
  assign done_ready = (state == S_IWR) && mem_ack && (k == klast_wr) && c_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; wide <= 1'b0; scan <= 1'b0; irq <= 1'b0;
      nf_pend <= 1'b0; c_ext <= 1'b0; base <= '0;
      oidx <= '0; iidx <= IN_FIRST; k <= 3'd0;
      ocode <= 8'h00; c_code <= 8'h00; c_ast <= 8'h00; c_dst <= 8'h00;
      ptr <= '0; nf_ptr <= '0; c_ptr <= '0; tv <= '0;
      for (int i = 0; i < NOUT; i++) tp[i] <= '0;
    end else begin
      if (scan_go) scan <= 1'b1;
      if (irq_clr) irq <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cfg_load) begin
            wide <= cfg_wide; base <= cfg_base;
            oidx <= '0; iidx <= IN_FIRST;
            scan <= 1'b0; tv <= '0; nf_pend <= 1'b0;
          end else if (nf_pend) begin
            c_ptr <= nf_ptr; c_code <= 8'h03; c_ast <= 8'h00; c_dst <= 8'h00;
            c_ext <= 1'b0; nf_pend <= 1'b0; state <= S_ICHK;
          end else if (done_valid) begin
            c_ptr <= done_ptr; c_code <= done_code; c_ast <= done_ast; c_dst <= done_dst;
            c_ext <= 1'b1; state <= S_ICHK;
          end else if (scan && !(&tv)) begin
            state <= S_OCODE;
          end
        end
        S_OCODE: if (mem_ack) begin
          if (mem_rdata == 8'h00) begin
            if (!scan_go) scan <= 1'b0;
            state <= S_IDLE;
          end else begin
            ocode <= mem_rdata; ptr <= '0; k <= 3'd0; state <= S_OPTR;
          end
        end
        S_OPTR: if (mem_ack) begin
          if (wide) ptr[{k[1:0], 3'b000} +: 8] <= mem_rdata;
          else      ptr <= {ptr[23:0], mem_rdata};
          if (k == klast_rd) state <= S_OCLR;
          else               k <= k + 3'd1;
        end
        S_OCLR: if (mem_ack) begin
          oidx <= (oidx == OUT_LAST) ? '0 : oidx + 1'b1;
          if (ocode == 8'h01) state <= S_DISP;
          else if (ocode == 8'h02) begin
            if (hit) state <= S_DISP;
            else begin
              nf_pend <= 1'b1; nf_ptr <= ptr; state <= S_IDLE;
            end
          end else state <= S_IDLE;
        end
        S_DISP: if (cmd_ready) begin
          if (ocode == 8'h01) begin
            tv[fidx] <= 1'b1; tp[fidx] <= ptr;
          end
          state <= S_IDLE;
        end
        S_ICHK: if (mem_ack && mem_rdata == 8'h00) begin
          k <= 3'd0; state <= S_IWR;
        end
        S_IWR: if (mem_ack) begin
          if (k == klast_wr) begin
            iidx <= (iidx == IN_LAST) ? IN_FIRST : iidx + 1'b1;
            irq  <= 1'b1;
            if (c_ext)
              for (int i = 0; i < NOUT; i++)
                if (tv[i] && tp[i] == c_ptr) tv[i] <= 1'b0;
            state <= S_IDLE;
          end else k <= k + 3'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_ring_engine_chk.sv
module mbox_ring_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_abort,
  input logic [31:0]   cmd_ptr,
  input logic          done_valid,
  input logic          done_ready,
  input logic [7:0]    done_code,
  input logic          irq_mbl
);
  a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_ptr) && $stable(cmd_abort));

  a_r12_done_pair: assert property (@(posedge clk) disable iff (!rst_n)
    done_ready |-> done_valid);

  a_r6_code_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_ready |-> mem_req && mem_we && mem_wdata == done_code);

  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_mbl) |-> $past(mem_req && mem_ack && mem_we));
endmodule

bind mbox_ring_engine mbox_ring_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbox_ring_engine_tb.sv
module mbox_ring_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [7:0] B = 8'h10;

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, cfg_wide = 0, scan_go = 0, irq_clr = 0;
  logic [31:0] cfg_base = 0;
  logic irq_mbl, mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic cmd_valid, cmd_abort, cmd_ready = 1;
  logic [31:0] cmd_ptr;
  logic done_valid = 0, done_ready;
  logic [31:0] done_ptr = 0;
  logic [7:0] done_code = 0, done_ast = 0, done_dst = 0;

  int total = 0, bad = 0, ncmd = 0, viol = 0;
  bit finished = 0;
  logic [31:0] lg_ptr [0:15];
  logic        lg_ab  [0:15];
  logic [7:0]  mem [0:255];
  logic h_we = 0, h_clr = 0, last_pend = 0;
  logic [7:0] h_a = 0, h_d = 0;
  int acnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_ring_engine #(.NMBOX(N), .NOUT(8), .AW(32)) u_dut (.*);

  always @(posedge clk) begin
    if (h_clr) for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    else if (h_we) mem[h_a] <= h_d;
    if (!rst_n) begin mem_ack <= 0; acnt <= 0; end
    else if (mem_req && !mem_ack) begin
      if (acnt == 1) begin
        mem_ack <= 1; acnt <= 0;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:0]];
      end else acnt <= acnt + 1;
    end else mem_ack <= 0;
  end

  always @(negedge clk) begin
    if (rst_n && last_pend && !mem_req) viol++;
    last_pend = mem_req && !mem_ack;
    if (cmd_valid && cmd_ready && ncmd < 16) begin
      lg_ptr[ncmd] = cmd_ptr; lg_ab[ncmd] = cmd_abort; ncmd++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); h_we = 1; h_a = a; h_d = d;
    @(negedge clk); h_we = 0;
  endtask

  task automatic clear_mem();
    @(negedge clk); h_clr = 1;
    @(negedge clk); h_clr = 0;
  endtask

  task automatic cfg(input logic w);
    @(negedge clk); cfg_load = 1; cfg_wide = w; cfg_base = {24'h0, B};
    @(negedge clk); cfg_load = 0;
    ncmd = 0;
  endtask

  task automatic go();
    @(negedge clk); scan_go = 1;
    @(negedge clk); scan_go = 0;
  endtask

  task automatic put24(input int s, input logic [7:0] code, input logic [23:0] p);
    hwr(B + 8'(4*s) + 8'd1, p[23:16]);
    hwr(B + 8'(4*s) + 8'd2, p[15:8]);
    hwr(B + 8'(4*s) + 8'd3, p[7:0]);
    hwr(B + 8'(4*s), code);
  endtask

  task automatic put32(input int s, input logic [7:0] code, input logic [31:0] p);
    for (int i = 0; i < 4; i++) hwr(B + 8'(8*s + i), p[8*i +: 8]);
    hwr(B + 8'(8*s + 7), code);
  endtask

  task automatic drive_done(input logic [31:0] p, input logic [7:0] c, a, d);
    @(negedge clk); done_valid = 1; done_ptr = p; done_code = c; done_ast = a; done_dst = d;
  endtask

  task automatic wait_ready(input int maxw, output bit ok);
    ok = 0;
    for (int i = 0; i < maxw && !ok; i++) begin
      @(negedge clk);
      if (done_ready) ok = 1;
    end
    if (ok) begin @(posedge clk); @(negedge clk); done_valid = 0; end
  endtask

  task automatic complete(input logic [31:0] p, input logic [7:0] c, a, d);
    bit ok;
    drive_done(p, c, a, d);
    wait_ready(200, ok);
    chk("R12 done_ready given", 32'(ok), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);
    chk("R1 done_ready", 32'(done_ready), 0);
    chk("R1 irq_mbl", 32'(irq_mbl), 0);
  endtask

  task automatic t_narrow();
    clear_mem(); cfg(0);
    cmd_ready = 0;
    put24(0, 8'h01, 24'h123456);
    put24(1, 8'h01, 24'hABCDEF);
    put24(3, 8'h01, 24'h777777);
    go(); cyc(40);
    chk("R12 cmd_valid held", 32'(cmd_valid), 1);
    chk("R12 cmd_ptr held", cmd_ptr, 32'h00123456);
    cmd_ready = 1;
    cyc(80);
    chk("R5 two commands", ncmd, 2);
    chk("R2 ptr0 msb first", lg_ptr[0], 32'h00123456);
    chk("R2 ptr1", lg_ptr[1], 32'h00ABCDEF);
    chk("R4 start not abort", 32'(lg_ab[0]), 0);
    chk("R4 slot0 cleared", mem[B], 0);
    chk("R4 slot1 cleared", mem[B+4], 0);
    chk("R5 scan stopped at free slot", mem[B+12], 8'h01);
    chk("R11 no irq before completion", 32'(irq_mbl), 0);
    complete(32'h00123456, 8'h01, 8'h00, 8'h00);
    chk("R6 code", mem[B+16], 8'h01);
    chk("R6 ptr hi", mem[B+17], 8'h12);
    chk("R6 ptr mid", mem[B+18], 8'h34);
    chk("R6 ptr lo", mem[B+19], 8'h56);
    chk("R11 irq set", 32'(irq_mbl), 1);
    cyc(5);
    chk("R11 irq held", 32'(irq_mbl), 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R11 irq cleared", 32'(irq_mbl), 0);
  endtask

  task automatic t_wrap();
    bit ok;
    clear_mem(); cfg(0);
    put24(0, 8'h01, 24'h0000A0); put24(1, 8'h01, 24'h0000A1);
    go(); cyc(60);
    put24(2, 8'h01, 24'h0000A2); put24(3, 8'h01, 24'h0000A3); put24(0, 8'h01, 24'h0000A4);
    go(); cyc(80);
    chk("R5 five commands", ncmd, 5);
    chk("R5 order slot2", lg_ptr[2], 32'hA2);
    chk("R5 order slot3", lg_ptr[3], 32'hA3);
    chk("R5 wrap to slot0", lg_ptr[4], 32'hA4);
    for (int j = 0; j < 4; j++) complete(32'h00C0C000 + 32'(j), 8'h01, 8'h00, 8'h00);
    chk("R8 slot N first", mem[B+19], 8'h00);
    chk("R8 slot 2N-1", mem[B+31], 8'h03);
    drive_done(32'h00DDEEFF, 8'h04, 8'h00, 8'h00);
    wait_ready(50, ok);
    chk("R9 stalled while occupied", 32'(ok), 0);
    chk("R9 slot untouched", mem[B+19], 8'h00);
    hwr(B + 8'd16, 8'h00);
    wait_ready(100, ok);
    chk("R9 posted after free", 32'(ok), 1);
    chk("R8 wrap to N code", mem[B+16], 8'h04);
    chk("R8 wrap to N ptr", {mem[B+17], mem[B+18], mem[B+19]}, 32'hDDEEFF);
  endtask

  task automatic t_abort();
    clear_mem(); cfg(0);
    put24(0, 8'h01, 24'h000111);
    put24(1, 8'h02, 24'h000111);
    put24(2, 8'h02, 24'h000222);
    go(); cyc(120);
    chk("R10 only two issued", ncmd, 2);
    chk("R4 abort flagged", 32'(lg_ab[1]), 1);
    chk("R4 abort ptr", lg_ptr[1], 32'h111);
    chk("R4 abort slot cleared", mem[B+8], 0);
    chk("R10 not-found code", mem[B+16], 8'h03);
    chk("R10 not-found ptr", {mem[B+17], mem[B+18], mem[B+19]}, 32'h000222);
    chk("R11 irq on internal completion", 32'(irq_mbl), 1);
  endtask

  task automatic t_wide();
    clear_mem(); cfg(1);
    put32(0, 8'h01, 32'h12345678);
    hwr(B + 8'd38, 8'hEE);
    go(); cyc(60);
    chk("R3 one command", ncmd, 1);
    chk("R3 ptr lsb first", lg_ptr[0], 32'h12345678);
    chk("R3 code byte 7 cleared", mem[B+7], 0);
    complete(32'h12345678, 8'h04, 8'h11, 8'h02);
    chk("R7 ptr b0", mem[B+32], 8'h78);
    chk("R7 ptr b1", mem[B+33], 8'h56);
    chk("R7 ptr b2", mem[B+34], 8'h34);
    chk("R7 ptr b3", mem[B+35], 8'h12);
    chk("R7 timeout status", mem[B+36], 8'h11);
    chk("R7 device status", mem[B+37], 8'h02);
    chk("R7 pad zeroed", mem[B+38], 8'h00);
    chk("R7 code last", mem[B+39], 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_narrow();
    t_wrap();
    t_abort();
    t_wide();
    chk("R13 request held until ack", viol, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule